// File: doc/BRIEF.md
# Chunked Sector-Cache DMA Streamer

This block drains a sector cache into a memory write port, one bounded chunk per scheduler tick. A host first loads a read command (first sector address and sector count). It then sets a destination address, a byte length and a direction, and raises a start request while the enable input is high. Each tick then moves up to `CHUNK_MAX` bytes, one data beat per cycle. Whenever the cache runs dry while sectors are still owed, the block asks the sector source to refill it with up to `CACHE_SECT` sectors.

After every tick the working address and the transferred-byte counter advance by the bytes moved in that tick. When the transferred count reaches the programmed length, the block drops its busy state and pulses an end-of-transfer strobe. When the command has no sectors left and the cache is empty, a one-cycle command-complete strobe tells the packet controller that the read command is finished. Lowering enable during a transfer aborts it at once.

Top module: `sector_dma_stream`

## Requirements
- R1: A start request is ignored while `en` is 0 or while `busy` is 1; such a request changes neither `busy`, `work_addr`, `done_bytes` nor the error flags.
- R2: An accepted start (with `en`=1, `busy`=0, length aligned and direction valid) sets `busy` one cycle later, loads `work_addr` from `base_addr` and clears `done_bytes` to 0.
- R3: A start whose `xfer_len` has any of bits [4:0] set raises `err_len`, leaves `busy` at 0 and causes no memory write.
- R4: A start with `dir_to_mem`=0 (only `dir_to_mem`=1, device to memory, is supported) raises `err_dir`, leaves `busy` at 0 and transfers nothing.
- R5: One tick moves at most `CHUNK_MAX` bytes and never more than the length still owed. When no sectors remain at the tick, it moves no more than the bytes left in the cache.
- R6: A refill request carries `fill_lba` equal to the next unread sector and `fill_cnt` = min(remaining sectors, `CACHE_SECT`). On `fill_done` the remaining count drops, and the next sector address rises, by `fill_cnt`.
- R7: The k-th beat of a transfer writes byte address `base_addr` + k·`DATA_W`/8. Its data is the next word of the sector stream, in ascending sector and then word order.
- R8: After each tick, `work_addr` and `done_bytes` have both advanced by exactly the bytes moved in that tick.
- R9: When `done_bytes` reaches the programmed length, `busy` clears and `dma_end` pulses for one cycle.
- R10: At the end of a tick, if the loaded command has no sectors left and the cache is empty, `cmd_done` pulses for one cycle, once per loaded command.
- R11: Lowering `en` during a transfer aborts it. No memory write occurs while `en` is 0, `busy` clears, `dma_end` does not pulse, and the bytes of the interrupted chunk are not added to `done_bytes`.
- R12: If the sector stream runs out in the middle of a tick, the tick ends with the bytes already moved and the transfer stays busy without pulsing `dma_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Engine enable level; a low level aborts |
| start_req | input | 1 | One-cycle start request |
| base_addr | input | ADDR_W | Destination start address |
| xfer_len | input | LEN_W | Transfer length in bytes |
| dir_to_mem | input | 1 | 1 = device to memory |
| tick | input | 1 | Scheduler tick, one chunk per pulse |
| cmd_load | input | 1 | Load a new read command |
| cmd_lba | input | LBA_W | First sector of the command |
| cmd_sectors | input | LBA_W | Sector count of the command |
| fill_req | output | 1 | Refill request pulse to the sector source |
| fill_lba | output | LBA_W | First sector to fetch |
| fill_cnt | output | $clog2(CACHE_SECT+1) | Sectors to fetch |
| fill_done | input | 1 | Refill complete, cache contents valid |
| cache_raddr | output | $clog2(CACHE_SECT*SECT_BYTES*8/DATA_W) | Cache word read address |
| cache_rdata | input | DATA_W | Cache word read data (same cycle) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| busy | output | 1 | Transfer in progress |
| work_addr | output | ADDR_W | Working destination address |
| done_bytes | output | LEN_W | Bytes transferred so far |
| dma_end | output | 1 | End-of-transfer pulse |
| cmd_done | output | 1 | Command-complete pulse |
| err_len | output | 1 | Last start had a misaligned length |
| err_dir | output | 1 | Last start had an unsupported direction |

## Verification
The assertions assume three things. `xfer_len` and `base_addr` stay constant from an accepted start until the transfer ends. `tick` arrives only when the previous chunk has finished. `fill_done` answers each refill request exactly once. The bench meets all three by driving ticks only after a settling window longer than the largest chunk plus its refills, and by holding the transfer registers for the whole transfer. Its sector-source model answers every request exactly once after a fixed latency. Random commands with random sector counts and 32-byte-multiple lengths cover lengths shorter than, equal to and longer than the available data.

// File: rtl/sdma_pkg.sv
// Shared types for the sector DMA streamer.
// Assumes: nothing beyond IEEE 1800-2017.
package sdma_pkg;
    typedef enum logic [1:0] {
        ENG_IDLE,   // waiting for a tick
        ENG_RUN,    // moving beats of the current chunk
        ENG_FILL,   // waiting for a cache refill
        ENG_WRAP    // committing the chunk totals
    } eng_state_e;
endpackage

// File: rtl/sdma_ctrl.sv
// Control registers: start acceptance, error flags, busy, working address
// and transferred-byte counter.
// Assumes: finish and commit arrive only while busy; moved is the chunk size.
module sdma_ctrl #(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 24,
    parameter int ALIGN_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start_req,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              dir_to_mem,
    input  logic              finish,
    input  logic              commit,
    input  logic [LEN_W-1:0]  moved,
    output logic              busy,
    output logic              err_len,
    output logic              err_dir,
    output logic [ADDR_W-1:0] work_addr,
    output logic [LEN_W-1:0]  done_bytes,
    output logic [LEN_W-1:0]  len_q
);
    localparam int AL_W = $clog2(ALIGN_BYTES);

    logic start_ok;
    logic len_bad;
    logic go;

    // Decode whether a start request is taken and whether it is valid.
    always_comb begin
        start_ok = start_req && en && !busy;
        len_bad  = |xfer_len[AL_W-1:0];
        go       = start_ok && !len_bad && dir_to_mem;
    end

    // Busy flag: set by a valid start, cleared by abort or completion.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy <= 1'b0;
        else if (!en)    busy <= 1'b0;
        else if (go)     busy <= 1'b1;
        else if (finish) busy <= 1'b0;
    end

    // Error flags: refreshed on every accepted start request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_len <= 1'b0;
            err_dir <= 1'b0;
        end else if (start_ok) begin
            err_len <= len_bad;
            err_dir <= !dir_to_mem;
        end
    end

    // Working address, byte counter and length latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_addr  <= '0;
            done_bytes <= '0;
            len_q      <= '0;
        end else if (go) begin
            work_addr  <= base_addr;
            done_bytes <= '0;
            len_q      <= xfer_len;
        end else if (commit) begin
            work_addr  <= work_addr + ADDR_W'(moved);
            done_bytes <= done_bytes + moved;
        end
    end
endmodule

// File: rtl/sdma_sizer.sv
// Chunk sizer: bytes a tick may move, bounded by the per-tick limit, the
// bytes still owed and, with no sectors left, the bytes in the cache.
// Assumes: LEN_W is at least CB_W.
module sdma_sizer #(
    parameter int LEN_W     = 24,
    parameter int CB_W      = 17,
    parameter int CHUNK_MAX = 10240
) (
    input  logic [LEN_W-1:0] len_q,
    input  logic [LEN_W-1:0] done_bytes,
    input  logic [CB_W-1:0]  cache_bytes,
    input  logic             rem_zero,
    output logic [LEN_W-1:0] chunk
);
    logic [LEN_W-1:0] owed;
    logic [LEN_W-1:0] lim;
    logic [LEN_W-1:0] cache_ext;

    // Minimum of the three bounds.
    always_comb begin
        owed      = len_q - done_bytes;
        lim       = (owed < LEN_W'(CHUNK_MAX)) ? owed : LEN_W'(CHUNK_MAX);
        cache_ext = LEN_W'(cache_bytes);
        chunk     = (rem_zero && (cache_ext < lim)) ? cache_ext : lim;
    end
endmodule

// File: rtl/sdma_cache.sv
// Cache bookkeeping: remaining sectors, next sector address, valid bytes
// in the cache, read index, refill sizing and command activity.
// Assumes: fill_done answers each fill_issue once; cmd_load while idle.
module sdma_cache #(
    parameter int LBA_W      = 24,
    parameter int SECT_BYTES = 2048,
    parameter int CACHE_SECT = 32,
    parameter int BEAT_BYTES = 4,
    parameter int CB_W       = $clog2(CACHE_SECT*SECT_BYTES+1),
    parameter int CIDX_W     = $clog2(CACHE_SECT*SECT_BYTES/BEAT_BYTES),
    parameter int FC_W       = $clog2(CACHE_SECT+1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_load,
    input  logic [LBA_W-1:0]  cmd_lba,
    input  logic [LBA_W-1:0]  cmd_sectors,
    input  logic              fill_issue,
    input  logic              fill_done,
    input  logic              consume,
    input  logic              cmd_done,
    output logic [LBA_W-1:0]  rem,
    output logic [LBA_W-1:0]  next_lba,
    output logic [FC_W-1:0]   fill_cnt,
    output logic [CB_W-1:0]   cache_bytes,
    output logic [CIDX_W-1:0] cache_idx,
    output logic              fill_pend,
    output logic              cmd_active
);
    // Refill size: whole cache or whatever is left.
    always_comb begin
        fill_cnt = (rem > LBA_W'(CACHE_SECT)) ? FC_W'(CACHE_SECT) : FC_W'(rem);
    end

    // Sector stream and cache occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem         <= '0;
            next_lba    <= '0;
            cache_bytes <= '0;
            cache_idx   <= '0;
        end else if (cmd_load) begin
            rem         <= cmd_sectors;
            next_lba    <= cmd_lba;
            cache_bytes <= '0;
            cache_idx   <= '0;
        end else if (fill_done) begin
            rem         <= rem - LBA_W'(fill_cnt);
            next_lba    <= next_lba + LBA_W'(fill_cnt);
            cache_bytes <= CB_W'(fill_cnt) * CB_W'(SECT_BYTES);
            cache_idx   <= '0;
        end else if (consume) begin
            cache_bytes <= cache_bytes - CB_W'(BEAT_BYTES);
            cache_idx   <= cache_idx + 1'b1;
        end
    end

    // Outstanding refill marker.
    always_ff @(posedge clk) begin
        if (!rst_n)          fill_pend <= 1'b0;
        else if (fill_done)  fill_pend <= 1'b0;
        else if (fill_issue) fill_pend <= 1'b1;
    end

    // Command activity: set on load, cleared when completion is signalled.
    always_ff @(posedge clk) begin
        if (!rst_n)         cmd_active <= 1'b0;
        else if (cmd_load)  cmd_active <= 1'b1;
        else if (cmd_done)  cmd_active <= 1'b0;
    end
endmodule

// File: rtl/sdma_engine.sv
// Chunk engine: on a tick moves one chunk beat by beat, requests refills
// when the cache is empty, and emits commit, end and completion strobes.
// Assumes: tick is offered only while idle; cache bytes are beat multiples.
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int LBA_W      = 24,
    parameter int CB_W       = 17,
    parameter int BEAT_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             en,
    input  logic             tick,
    input  logic [LEN_W-1:0] chunk,
    input  logic [LEN_W-1:0] len_q,
    input  logic [LEN_W-1:0] done_bytes,
    input  logic [CB_W-1:0]  cache_bytes,
    input  logic [LBA_W-1:0] rem,
    input  logic             fill_pend,
    input  logic             fill_done,
    input  logic             cmd_active,
    output logic             beat,
    output logic             fill_issue,
    output logic             commit,
    output logic             dma_end,
    output logic             cmd_done,
    output logic [LEN_W-1:0] moved
);
    eng_state_e       state;
    logic [LEN_W-1:0] left;
    logic             run_ok;
    logic             cache_empty;
    logic             rem_zero;

    // Strobes decoded from the state and the bookkeeping inputs.
    always_comb begin
        run_ok      = busy && en;
        cache_empty = (cache_bytes == '0);
        rem_zero    = (rem == '0);
        beat        = (state == ENG_RUN) && run_ok && (left != '0) && !cache_empty;
        fill_issue  = (state == ENG_RUN) && run_ok && (left != '0) && cache_empty
                      && !rem_zero && !fill_pend;
        commit      = (state == ENG_WRAP) && run_ok;
        dma_end     = commit && ((done_bytes + moved) == len_q);
        cmd_done    = commit && cmd_active && rem_zero && cache_empty;
    end

    // Chunk sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ENG_IDLE;
            left  <= '0;
            moved <= '0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (run_ok && tick) begin
                        left  <= chunk;
                        moved <= '0;
                        state <= ENG_RUN;
                    end
                end
                ENG_RUN: begin
                    if (!run_ok) begin
                        state <= ENG_IDLE;
                    end else if (left == '0) begin
                        state <= ENG_WRAP;
                    end else if (cache_empty) begin
                        state <= rem_zero ? ENG_WRAP : ENG_FILL;
                    end else begin
                        left  <= left - LEN_W'(BEAT_BYTES);
                        moved <= moved + LEN_W'(BEAT_BYTES);
                    end
                end
                ENG_FILL: begin
                    if (!run_ok)        state <= ENG_IDLE;
                    else if (fill_done) state <= ENG_RUN;
                end
                ENG_WRAP: state <= ENG_IDLE;
                default:  state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sector_dma_stream.sv
// Top of the sector DMA streamer: wires control, sizing, cache bookkeeping
// and the chunk engine; data passes from the cache read port to memory.
// Assumes: cache_rdata is valid in the cycle cache_raddr is driven;
// DATA_W/8 divides SECT_BYTES, CHUNK_MAX and 32; ADDR_W >= LEN_W >= cache byte width.
module sector_dma_stream #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 24,
    parameter int LBA_W      = 24,
    parameter int DATA_W     = 32,
    parameter int SECT_BYTES = 2048,
    parameter int CACHE_SECT = 32,
    parameter int CHUNK_MAX  = 10240
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              en,
    input  logic                                              start_req,
    input  logic [ADDR_W-1:0]                                 base_addr,
    input  logic [LEN_W-1:0]                                  xfer_len,
    input  logic                                              dir_to_mem,
    input  logic                                              tick,
    input  logic                                              cmd_load,
    input  logic [LBA_W-1:0]                                  cmd_lba,
    input  logic [LBA_W-1:0]                                  cmd_sectors,
    output logic                                              fill_req,
    output logic [LBA_W-1:0]                                  fill_lba,
    output logic [$clog2(CACHE_SECT+1)-1:0]                   fill_cnt,
    input  logic                                              fill_done,
    output logic [$clog2(CACHE_SECT*SECT_BYTES*8/DATA_W)-1:0] cache_raddr,
    input  logic [DATA_W-1:0]                                 cache_rdata,
    output logic                                              mem_we,
    output logic [ADDR_W-1:0]                                 mem_addr,
    output logic [DATA_W-1:0]                                 mem_wdata,
    output logic                                              busy,
    output logic [ADDR_W-1:0]                                 work_addr,
    output logic [LEN_W-1:0]                                  done_bytes,
    output logic                                              dma_end,
    output logic                                              cmd_done,
    output logic                                              err_len,
    output logic                                              err_dir
);
    localparam int BEAT_BYTES  = DATA_W / 8;
    localparam int CACHE_BYTES = CACHE_SECT * SECT_BYTES;
    localparam int CB_W        = $clog2(CACHE_BYTES + 1);
    localparam int CIDX_W      = $clog2(CACHE_BYTES / BEAT_BYTES);
    localparam int FC_W        = $clog2(CACHE_SECT + 1);

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] chunk;
    logic [LEN_W-1:0] moved;
    logic [LBA_W-1:0] rem;
    logic [CB_W-1:0]  cache_bytes;
    logic             fill_pend;
    logic             cmd_active;
    logic             beat;
    logic             fill_issue;
    logic             commit;

    sdma_ctrl #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .ALIGN_BYTES(32)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .start_req (start_req),
        .base_addr (base_addr),
        .xfer_len  (xfer_len),
        .dir_to_mem(dir_to_mem),
        .finish    (dma_end),
        .commit    (commit),
        .moved     (moved),
        .busy      (busy),
        .err_len   (err_len),
        .err_dir   (err_dir),
        .work_addr (work_addr),
        .done_bytes(done_bytes),
        .len_q     (len_q)
    );

    sdma_sizer #(
        .LEN_W    (LEN_W),
        .CB_W     (CB_W),
        .CHUNK_MAX(CHUNK_MAX)
    ) sizer_i (
        .len_q      (len_q),
        .done_bytes (done_bytes),
        .cache_bytes(cache_bytes),
        .rem_zero   (rem == '0),
        .chunk      (chunk)
    );

    sdma_cache #(
        .LBA_W     (LBA_W),
        .SECT_BYTES(SECT_BYTES),
        .CACHE_SECT(CACHE_SECT),
        .BEAT_BYTES(BEAT_BYTES),
        .CB_W      (CB_W),
        .CIDX_W    (CIDX_W),
        .FC_W      (FC_W)
    ) cache_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_load   (cmd_load),
        .cmd_lba    (cmd_lba),
        .cmd_sectors(cmd_sectors),
        .fill_issue (fill_issue),
        .fill_done  (fill_done),
        .consume    (beat),
        .cmd_done   (cmd_done),
        .rem        (rem),
        .next_lba   (fill_lba),
        .fill_cnt   (fill_cnt),
        .cache_bytes(cache_bytes),
        .cache_idx  (cache_raddr),
        .fill_pend  (fill_pend),
        .cmd_active (cmd_active)
    );

    sdma_engine #(
        .LEN_W     (LEN_W),
        .LBA_W     (LBA_W),
        .CB_W      (CB_W),
        .BEAT_BYTES(BEAT_BYTES)
    ) engine_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .en         (en),
        .tick       (tick),
        .chunk      (chunk),
        .len_q      (len_q),
        .done_bytes (done_bytes),
        .cache_bytes(cache_bytes),
        .rem        (rem),
        .fill_pend  (fill_pend),
        .fill_done  (fill_done),
        .cmd_active (cmd_active),
        .beat       (beat),
        .fill_issue (fill_issue),
        .commit     (commit),
        .dma_end    (dma_end),
        .cmd_done   (cmd_done),
        .moved      (moved)
    );

    // Memory write port: beat data straight from the cache read port.
    always_comb begin
        fill_req  = fill_issue;
        mem_we    = beat;
        mem_addr  = work_addr + ADDR_W'(moved);
        mem_wdata = cache_rdata;
    end
endmodule

// File: rtl/sector_dma_stream_chk.sv
// Assertion checker for the sector DMA streamer, bound to the top module.
// Assumes: xfer_len and base_addr held during a transfer; tick only while idle.
module sector_dma_stream_chk #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 24,
    parameter int DATA_W     = 32,
    parameter int FC_W       = 6,
    parameter int CACHE_SECT = 32,
    parameter int CHUNK_MAX  = 10240
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              start_req,
    input logic [ADDR_W-1:0] base_addr,
    input logic [LEN_W-1:0]  xfer_len,
    input logic              dir_to_mem,
    input logic              tick,
    input logic              fill_req,
    input logic [FC_W-1:0]   fill_cnt,
    input logic              mem_we,
    input logic              busy,
    input logic [ADDR_W-1:0] work_addr,
    input logic [LEN_W-1:0]  done_bytes,
    input logic              dma_end,
    input logic              cmd_done,
    input logic              err_len,
    input logic              err_dir
);
    logic [31:0] tick_bytes;

    // Bytes written since the most recent tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      tick_bytes <= '0;
        else if (tick)   tick_bytes <= '0;
        else if (mem_we) tick_bytes <= tick_bytes + 32'(DATA_W / 8);
    end

    assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);

    assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && en && !busy && (xfer_len[4:0] == 5'd0) && dir_to_mem)
        |=> (busy && (done_bytes == '0) && (work_addr == $past(base_addr))));

    assert_bad_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && en && !busy && (xfer_len[4:0] != 5'd0)) |=> (!busy && err_len));

    assert_bad_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && en && !busy && !dir_to_mem) |=> (!busy && err_dir));

    assert_chunk_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_bytes <= 32'(CHUNK_MAX));

    assert_fill_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> ((fill_cnt != '0) && (fill_cnt <= FC_W'(CACHE_SECT))));

    assert_end_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_end |=> (!busy && !dma_end));

    assert_end_total_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_end |=> (done_bytes == xfer_len));

    assert_cmd_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    assert_no_write_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (en && busy));
endmodule

bind sector_dma_stream sector_dma_stream_chk #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .DATA_W    (DATA_W),
    .FC_W      ($clog2(CACHE_SECT+1)),
    .CACHE_SECT(CACHE_SECT),
    .CHUNK_MAX (CHUNK_MAX)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .start_req (start_req),
    .base_addr (base_addr),
    .xfer_len  (xfer_len),
    .dir_to_mem(dir_to_mem),
    .tick      (tick),
    .fill_req  (fill_req),
    .fill_cnt  (fill_cnt),
    .mem_we    (mem_we),
    .busy      (busy),
    .work_addr (work_addr),
    .done_bytes(done_bytes),
    .dma_end   (dma_end),
    .cmd_done  (cmd_done),
    .err_len   (err_len),
    .err_dir   (err_dir)
);

// File: tb/sector_dma_stream_tb_top.sv
// Self-checking bench: sector-source model, memory monitor, reference model
// of chunk sizing and refills, directed corner cases and random transfers.
module sector_dma_stream_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int LEN_W      = 16;
    localparam int LBA_W      = 16;
    localparam int DATA_W     = 32;
    localparam int SECT_BYTES = 64;
    localparam int CACHE_SECT = 4;
    localparam int CHUNK_MAX  = 320;
    localparam int BEAT       = DATA_W / 8;
    localparam int WPS        = SECT_BYTES / BEAT;
    localparam int CWORDS     = CACHE_SECT * WPS;
    localparam int CIDX_W     = $clog2(CWORDS);
    localparam int FC_W       = $clog2(CACHE_SECT + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic              start_req = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [LEN_W-1:0]  xfer_len = '0;
    logic              dir_to_mem = 1'b1;
    logic              tick = 1'b0;
    logic              cmd_load = 1'b0;
    logic [LBA_W-1:0]  cmd_lba = '0;
    logic [LBA_W-1:0]  cmd_sectors = '0;
    logic              fill_req;
    logic [LBA_W-1:0]  fill_lba;
    logic [FC_W-1:0]   fill_cnt;
    logic              fill_done = 1'b0;
    logic [CIDX_W-1:0] cache_raddr;
    logic [DATA_W-1:0] cache_rdata;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              busy;
    logic [ADDR_W-1:0] work_addr;
    logic [LEN_W-1:0]  done_bytes;
    logic              dma_end;
    logic              cmd_done;
    logic              err_len;
    logic              err_dir;

    logic [DATA_W-1:0] cache_mem [CWORDS];

    int n_chk = 0;
    int n_bad = 0;

    // Monitor and model state.
    int cur_base, xfer_pos, p_stream, s_lba;
    int mon_lba, mon_rem;
    int wr_cnt = 0, dend_cnt = 0, cdone_cnt = 0;
    int m_rem, m_cache, m_done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign cache_rdata = cache_mem[cache_raddr];

    sector_dma_stream #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LBA_W(LBA_W), .DATA_W(DATA_W),
        .SECT_BYTES(SECT_BYTES), .CACHE_SECT(CACHE_SECT), .CHUNK_MAX(CHUNK_MAX)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .start_req(start_req),
        .base_addr(base_addr), .xfer_len(xfer_len), .dir_to_mem(dir_to_mem),
        .tick(tick), .cmd_load(cmd_load), .cmd_lba(cmd_lba),
        .cmd_sectors(cmd_sectors), .fill_req(fill_req), .fill_lba(fill_lba),
        .fill_cnt(fill_cnt), .fill_done(fill_done), .cache_raddr(cache_raddr),
        .cache_rdata(cache_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy), .work_addr(work_addr),
        .done_bytes(done_bytes), .dma_end(dma_end), .cmd_done(cmd_done),
        .err_len(err_len), .err_dir(err_dir)
    );

    function automatic logic [31:0] pat(int lba, int w);
        return {16'(lba) ^ 16'h5A00, 16'(w)};
    endfunction

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Sector source model: answers each refill after a fixed latency.
    initial begin
        forever begin
            @(negedge clk);
            if (fill_req) begin
                automatic int lba = int'(fill_lba);
                automatic int cnt = int'(fill_cnt);
                repeat (3) @(negedge clk);
                for (int s = 0; s < cnt; s++)
                    for (int w = 0; w < WPS; w++)
                        cache_mem[s*WPS + w] = pat(lba + s, w);
                fill_done = 1'b1;
                @(negedge clk);
                fill_done = 1'b0;
            end
        end
    end

    // Output monitor: writes, refill requests and strobes.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_we) begin
                check("R7 address", mem_addr, 32'(cur_base + xfer_pos));
                check("R7 data", mem_wdata,
                      pat(s_lba + p_stream / SECT_BYTES, (p_stream % SECT_BYTES) / BEAT));
                xfer_pos += BEAT;
                p_stream += BEAT;
                wr_cnt++;
            end
            if (fill_req) begin
                check("R6 fill_lba", fill_lba, 16'(mon_lba));
                check("R6 fill_cnt", fill_cnt, imin(mon_rem, CACHE_SECT));
                mon_lba += imin(mon_rem, CACHE_SECT);
                mon_rem -= imin(mon_rem, CACHE_SECT);
            end
            if (dma_end)  dend_cnt++;
            if (cmd_done) cdone_cnt++;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (180000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic load_cmd(input int lba, input int secs);
        @(negedge clk);
        cmd_lba = 16'(lba); cmd_sectors = 16'(secs); cmd_load = 1'b1;
        @(negedge clk);
        cmd_load = 1'b0;
        s_lba = lba; p_stream = 0; mon_lba = lba; mon_rem = secs;
        m_rem = secs; m_cache = 0; cdone_cnt = 0;
    endtask

    task automatic pulse_start(input int base, input int len);
        base_addr = 32'(base); xfer_len = 16'(len);
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
    endtask

    task automatic abort_xfer();
        @(negedge clk) en = 1'b0;
        @(negedge clk) en = 1'b1;
    endtask

    // Reference model of one tick: returns the bytes it moves.
    task automatic model_tick(input int len, output int mv);
        automatic int lim = imin(CHUNK_MAX, len - m_done);
        if (m_rem == 0) lim = imin(lim, m_cache);
        mv = 0;
        while (mv < lim) begin
            if (m_cache == 0) begin
                automatic int n;
                if (m_rem == 0) break;
                n = imin(m_rem, CACHE_SECT);
                m_cache = n * SECT_BYTES;
                m_rem -= n;
            end
            begin
                automatic int take = imin(lim - mv, m_cache);
                mv += take;
                m_cache -= take;
            end
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (200) @(negedge clk);
    endtask

    // One full transfer checked against the model, tick by tick.
    task automatic run_xfer(input int lba, input int secs, input int len, input int base);
        int mv;
        load_cmd(lba, secs);
        dir_to_mem = 1'b1;
        cur_base = base; xfer_pos = 0; dend_cnt = 0; m_done = 0;
        pulse_start(base, len);
        check("R2 busy", busy, 1);
        check("R2 work_addr", work_addr, 32'(base));
        check("R2 done_bytes", done_bytes, 0);
        for (int t = 0; t < 40; t++) begin
            model_tick(len, mv);
            do_tick();
            m_done += mv;
            check("R5 R8 done_bytes", done_bytes, 16'(m_done));
            check("R8 work_addr", work_addr, 32'(base + m_done));
            if (m_done == len) begin
                check("R9 dma_end count", dend_cnt, 1);
                check("R9 busy cleared", busy, 0);
                break;
            end
            if (mv == 0) break;
        end
        check("R10 cmd_done count", cdone_cnt, (m_rem == 0 && m_cache == 0) ? 1 : 0);
        if (busy) abort_xfer();
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        check("reset busy", busy, 0);
        check("reset mem_we", mem_we, 0);
        check("reset done_bytes", done_bytes, 0);
        check("reset err_len", err_len, 0);
        check("reset err_dir", err_dir, 0);
        en = 1'b1;

        // R4: unsupported direction.
        dir_to_mem = 1'b0;
        pulse_start(32'h100, 64);
        check("R4 err_dir", err_dir, 1);
        check("R4 busy", busy, 0);
        repeat (5) @(negedge clk);
        check("R4 no writes", wr_cnt, 0);

        // R1: start while disabled is ignored (error flag untouched).
        dir_to_mem = 1'b1;
        en = 1'b0;
        pulse_start(32'h200, 64);
        check("R1 busy while disabled", busy, 0);
        check("R1 err_dir kept", err_dir, 1);
        en = 1'b1;

        // R3: misaligned length.
        load_cmd(10, 4);
        pulse_start(32'h300, 16'h0024);
        check("R3 err_len", err_len, 1);
        check("R3 busy", busy, 0);
        do_tick();
        check("R3 no writes", wr_cnt, 0);

        // R1: start while busy ignored.
        load_cmd(100, 10);
        cur_base = 32'h1000; xfer_pos = 0;
        pulse_start(32'h1000, 640);
        pulse_start(32'h7000, 64);
        check("R1 work_addr unchanged", work_addr, 32'h1000);
        abort_xfer();

        // Directed: full transfer over several ticks and refills.
        run_xfer(100, 10, 640, 32'h1000);
        // Length shorter than available data.
        run_xfer(200, 8, 96, 32'h2000);
        // Zero length.
        run_xfer(300, 0, 0, 32'h3000);

        // R12: data runs out mid-tick.
        run_xfer(400, 2, 256, 32'h4000);
        check("R12 done_bytes after shortfall", done_bytes, 128);
        check("R12 no dma_end", dend_cnt, 0);

        // R11: abort mid-chunk, then restart.
        load_cmd(500, 12);
        cur_base = 32'h5000; xfer_pos = 0; dend_cnt = 0;
        pulse_start(32'h5000, 768);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (20) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        begin
            automatic int w0 = wr_cnt;
            repeat (50) @(negedge clk);
            check("R11 writes stopped", wr_cnt, w0);
        end
        check("R11 busy cleared", busy, 0);
        check("R11 no dma_end", dend_cnt, 0);
        check("R11 partial not counted", done_bytes, 0);
        en = 1'b1;
        pulse_start(32'h8000, 64);
        check("R2 restart work_addr", work_addr, 32'h8000);
        check("R2 restart done_bytes", done_bytes, 0);
        abort_xfer();

        // Random transfers.
        for (int i = 0; i < 30; i++) begin
            automatic int secs = int'($urandom_range(0, 12));
            automatic int len  = 32 * int'($urandom_range(0, (secs * SECT_BYTES) / 32 + 4));
            automatic int lba  = int'($urandom_range(0, 4000));
            automatic int base = 32 * int'($urandom_range(0, 50000));
            run_xfer(lba, secs, len, base);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule